// File: doc/BRIEF.md
# Hamming Sector Code Checker and Single-Bit Locator

This block takes two 24-bit Hamming codes for one 512-byte flash sector: the code that was stored in the spare area when the sector was written, and the code that the read path has just recomputed over the data. It decides whether the sector is clean, holds one flipped data bit that can be repaired, or is damaged beyond repair. For the repairable case it names the byte offset inside the sector and the bit inside that byte. It also raises a flip request that carries the offset and a one-hot byte mask, which a separate read-modify-write port applies to the sector buffer.

The block is a small state machine. In `S_IDLE` it waits for `start`; the transition *accept* captures both codes and enters `S_SYND`. There the two codes are restored to raw parity form (inverted), XORed and reordered into a 24-bit syndrome. The transition *match* goes straight to `S_DONE` when the syndrome is zero, and *mismatch* goes to `S_COUNT` otherwise. `S_COUNT` registers the population count of the syndrome and takes the transition *counted* to `S_CLASSIFY`. There *decide* registers the status and the location and enters `S_DONE`. `S_DONE` holds `done` for one cycle and then takes *release* back to `S_IDLE`. The outputs keep their values until the next result.

Top module: `ecc_fix`

## Requirements
- R1: When `stored_code` equals `calc_code`, the status is clean (encoding 2'b00) with offset and bit index zero. `done` is high in the cycle that follows the first rising edge after the edge that samples `start`.
- R2: The syndrome is formed from d = stored_code XOR calc_code, with byte 0 at bits 7:0, byte 1 at bits 15:8 and byte 2 at bits 23:16. Syndrome bits 5:0 are d[23:18], bits 13:6 are d[7:0], bits 21:14 are d[15:8], and bits 23:22 are d[17:16].
- R3: A mismatch whose syndrome has exactly 12 set bits is reported as corrected (status 2'b01).
- R4: In the corrected case, the 3-bit bit index is {syndrome[5], syndrome[3], syndrome[1]}.
- R5: In the corrected case, the 9-bit byte offset is made of the odd syndrome bits 23, 21, …, 9, 7, with bit 23 as the MSB.
- R6: `flip_req` is high only in the `done` cycle of a corrected result. In that cycle `flip_off` equals the offset and `flip_mask` equals 1 shifted left by the bit index.
- R7: A stored code of all ones together with a computed code of all zeros is an erased sector and is reported as clean (2'b00).
- R8: Every other mismatch is reported as uncorrectable (status 2'b10), with offset and bit index zero and no flip request. This covers syndrome weights of 1, 11 and 24, and a stored code of zero against a computed code of all ones.
- R9: For a mismatch, `done` is high in the cycle that follows the third rising edge after the edge that samples `start`. `done` lasts one cycle.
- R10: `start` has no effect while a check is in progress. The result belongs to the codes captured first, and no second `done` follows.
- R11: During reset and right after it, `done` and `flip_req` are low and the status is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; the codes are sampled on the same edge |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the sector data |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| byte_off | output | 9 | Failing byte offset (corrected case only, else 0) |
| bit_idx | output | 3 | Failing bit inside the byte (corrected case only, else 0) |
| flip_req | output | 1 | Request to invert one sector bit, during `done` |
| flip_off | output | 9 | Byte offset for the flip request |
| flip_mask | output | 8 | One-hot bit mask for the flip request |

## Verification
The bench drives single-bit errors at the extreme locations: offset 0 bit 0, offset 511 bit 7, and a location in the middle. If an odd syndrome bit were routed to the wrong place, or the MSB order were reversed, those cases would show a wrong offset or mask. It sends syndromes of weight 1, 11 and 24. A classifier that tested "nonzero" instead of exactly twelve would then flip a bit in a sector it cannot repair. The erased pattern and its mirror image are both applied, so a design that matches the erased case without regard to direction fails one of the two. A second `start` is held during a check; a design that re-arms there would produce a second `done` or a result for the wrong codes.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    localparam int ECC_OFF_W = 9;
    localparam int ECC_BIT_W = 3;
    localparam int ECC_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SYND,
        S_COUNT,
        S_CLASSIFY,
        S_DONE
    } ecc_fsm_t;
endpackage

// File: rtl/ecc_synd_map.sv
// Restores both codes to raw parity form and reorders their difference
// into the syndrome bit order that the locator decodes (R2).
module ecc_synd_map #(
    parameter int CODE_W = 24,
    parameter int BYTE_W = 8,
    parameter int TOP_LO = 2
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output logic [CODE_W-1:0] synd
);
    localparam int B2 = 2 * BYTE_W;

    logic [CODE_W-1:0] raw_s, raw_c, diff;

    always_comb begin
        raw_s = ~stored;
        raw_c = ~calc;
        diff  = raw_s ^ raw_c;
        synd  = {diff[B2+TOP_LO-1:B2], diff[B2-1:BYTE_W], diff[BYTE_W-1:0],
                 diff[CODE_W-1:B2+TOP_LO]};
    end
endmodule

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ecc_locator.sv
// Picks the odd syndrome bits: the low ones name the bit, the upper ones the byte.
module ecc_locator #(
    parameter int OFF_W = 9,
    parameter int BIT_W = 3,
    localparam int CODE_W = 2 * (OFF_W + BIT_W)
) (
    input  logic [CODE_W-1:0] synd,
    output logic [OFF_W-1:0]  off,
    output logic [BIT_W-1:0]  bidx
);
    for (genvar j = 0; j < BIT_W; j++) begin : g_bit
        assign bidx[j] = synd[2*j+1];
    end
    for (genvar k = 0; k < OFF_W; k++) begin : g_off
        assign off[k] = synd[2*(BIT_W+k)+1];
    end
endmodule

// File: rtl/ecc_fix.sv
module ecc_fix
    import ecc_fix_pkg::*;
#(
    parameter int OFF_W  = ECC_OFF_W,
    parameter int BIT_W  = ECC_BIT_W,
    parameter int BYTE_W = ECC_BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2*(OFF_W+BIT_W)-1:0] stored_code,
    input  logic [2*(OFF_W+BIT_W)-1:0] calc_code,
    output logic                    done,
    output logic [1:0]              status,
    output logic [OFF_W-1:0]        byte_off,
    output logic [BIT_W-1:0]        bit_idx,
    output logic                    flip_req,
    output logic [OFF_W-1:0]        flip_off,
    output logic [(1<<BIT_W)-1:0]   flip_mask
);
    localparam int CODE_W = 2 * (OFF_W + BIT_W);
    localparam int CW     = $clog2(CODE_W + 1);
    localparam int MASK_W = 1 << BIT_W;
    localparam logic [CW-1:0] FIX_WEIGHT = CW'(CODE_W / 2);

    ecc_fsm_t          state_q, state_d;
    logic [CODE_W-1:0] stored_q, calc_q, synd_w, synd_q;
    logic [CW-1:0]     weight_w, weight_q;
    logic              erased_q;
    ecc_status_t       status_q;
    logic [OFF_W-1:0]  off_w, off_q;
    logic [BIT_W-1:0]  bit_w, bit_q;

    ecc_synd_map #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .TOP_LO(2)) u_map (
        .stored(stored_q), .calc(calc_q), .synd(synd_w)
    );
    ecc_popcount #(.W(CODE_W)) u_pop (.vec(synd_q), .cnt(weight_w));
    ecc_locator #(.OFF_W(OFF_W), .BIT_W(BIT_W)) u_loc (
        .synd(synd_q), .off(off_w), .bidx(bit_w)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_SYND;
            S_SYND:     state_d = (synd_w == '0) ? S_DONE : S_COUNT;
            S_COUNT:    state_d = S_CLASSIFY;
            S_CLASSIFY: state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
            calc_q   <= '0;
            synd_q   <= '0;
            weight_q <= '0;
            erased_q <= 1'b0;
            status_q <= ST_CLEAN;
            off_q    <= '0;
            bit_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    stored_q <= stored_code;
                    calc_q   <= calc_code;
                end
                S_SYND: begin
                    synd_q   <= synd_w;
                    erased_q <= (stored_q == '1) && (calc_q == '0);
                    if (synd_w == '0) begin
                        status_q <= ST_CLEAN;
                        off_q    <= '0;
                        bit_q    <= '0;
                    end
                end
                S_COUNT: weight_q <= weight_w;
                S_CLASSIFY: begin
                    if (weight_q == FIX_WEIGHT) begin
                        status_q <= ST_FIXED;
                        off_q    <= off_w;
                        bit_q    <= bit_w;
                    end else begin
                        status_q <= erased_q ? ST_CLEAN : ST_FATAL;
                        off_q    <= '0;
                        bit_q    <= '0;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done      = (state_q == S_DONE);
        status    = status_q;
        byte_off  = off_q;
        bit_idx   = bit_q;
        flip_req  = done && (status_q == ST_FIXED);
        flip_off  = flip_req ? off_q : '0;
        flip_mask = flip_req ? (MASK_W'(1) << bit_q) : '0;
    end

    // Assertions
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_flip_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flip_req |-> ($countones(flip_mask) == 1) && done);
    assert_fixed_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_FIXED) |-> (weight_q == FIX_WEIGHT));
    assert_fatal_no_loc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_FATAL) |-> (byte_off == '0 && bit_idx == '0 && !flip_req));
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(stored_q) && $stable(calc_q));
    assert_match_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SYND && stored_q == calc_q) |=> done && status == ST_CLEAN);
endmodule

// File: tb/sim_ecc_fix.sv
module sim_ecc_fix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0, calc_code = '0;
    logic        done, flip_req;
    logic [1:0]  status;
    logic [8:0]  byte_off, flip_off;
    logic [2:0]  bit_idx;
    logic [7:0]  flip_mask;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ecc_fix u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .done(done), .status(status), .byte_off(byte_off), .bit_idx(bit_idx),
        .flip_req(flip_req), .flip_off(flip_off), .flip_mask(flip_mask)
    );

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            report();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Syndrome for a single error at (off, bit): odd bit = address bit, even = its complement
    function automatic logic [23:0] mk_synd(input logic [8:0] off, input logic [2:0] b);
        logic [11:0] a;
        logic [23:0] s;
        a = {off, b};
        for (int k = 0; k < 12; k++) begin
            s[2*k+1] = a[k];
            s[2*k]   = ~a[k];
        end
        return s;
    endfunction

    // Code difference producing a given syndrome (inverse of the R2 ordering)
    function automatic logic [23:0] mk_diff(input logic [23:0] s);
        return {s[5:0], s[23:22], s[21:14], s[13:6]};
    endfunction

    // Apply one check; returns the latency in cycles and the outputs at done
    task automatic run(input logic [23:0] sc, input logic [23:0] cc, output int lat,
                       output logic [1:0] st, output logic [8:0] off, output logic [2:0] bi,
                       output logic fr, output logic [8:0] fo, output logic [7:0] fm);
        @(negedge clk);
        stored_code = sc; calc_code = cc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        st = status; off = byte_off; bi = bit_idx; fr = flip_req; fo = flip_off; fm = flip_mask;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11", "done in reset", done, 0);
        chk("R11", "flip_req in reset", flip_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "status after reset", status, 0);
        chk("R11", "done after reset", done, 0);
    endtask

    task automatic t_equal(input logic [23:0] c);
        int lat; logic [1:0] st; logic [8:0] off, fo; logic [2:0] bi; logic fr; logic [7:0] fm;
        run(c, c, lat, st, off, bi, fr, fo, fm);
        chk("R1", "latency equal", lat, 1);
        chk("R1", "status equal", st, 0);
        chk("R1", "offset equal", off, 0);
        chk("R6", "no flip on equal", fr, 0);
    endtask

    task automatic t_single(input logic [23:0] base, input logic [8:0] o, input logic [2:0] b);
        int lat; logic [1:0] st; logic [8:0] off, fo; logic [2:0] bi; logic fr; logic [7:0] fm;
        run(base ^ mk_diff(mk_synd(o, b)), base, lat, st, off, bi, fr, fo, fm);
        chk("R9", "latency mismatch", lat, 3);
        chk("R3", "status corrected", st, 1);
        chk("R5", "byte offset", off, o);
        chk("R4", "bit index", bi, b);
        chk("R6", "flip_req", fr, 1);
        chk("R6", "flip_off", fo, o);
        chk("R6", "flip_mask", fm, 32'(8'd1 << b));
        @(negedge clk);
        chk("R9", "done one cycle", done, 0);
        chk("R6", "flip_req drops", flip_req, 0);
    endtask

    // Any weight-12 syndrome counts as corrected; location from odd bits (R2, R4, R5)
    task automatic t_weight12;
        int lat; logic [1:0] st; logic [8:0] off, fo; logic [2:0] bi; logic fr; logic [7:0] fm;
        run(24'h5A5A5A ^ mk_diff(24'h000FFF), 24'h5A5A5A, lat, st, off, bi, fr, fo, fm);
        chk("R3", "weight12 status", st, 1);
        chk("R2", "weight12 bit index", bi, 7);
        chk("R2", "weight12 offset", off, 9'd7);
    endtask

    task automatic t_fatal(input string what, input logic [23:0] sc, input logic [23:0] cc);
        int lat; logic [1:0] st; logic [8:0] off, fo; logic [2:0] bi; logic fr; logic [7:0] fm;
        run(sc, cc, lat, st, off, bi, fr, fo, fm);
        chk("R8", {what, " status"}, st, 2);
        chk("R8", {what, " offset"}, off, 0);
        chk("R8", {what, " bit"}, bi, 0);
        chk("R8", {what, " flip"}, fr, 0);
        chk("R9", {what, " latency"}, lat, 3);
    endtask

    task automatic t_erased;
        int lat; logic [1:0] st; logic [8:0] off, fo; logic [2:0] bi; logic fr; logic [7:0] fm;
        run(24'hFFFFFF, 24'h000000, lat, st, off, bi, fr, fo, fm);
        chk("R7", "erased status", st, 0);
        chk("R7", "erased flip", fr, 0);
    endtask

    task automatic t_busy;
        int lat;
        @(negedge clk);
        stored_code = 24'h123456 ^ mk_diff(mk_synd(9'd300, 3'd2));
        calc_code = 24'h123456; start = 1'b1;
        @(negedge clk);
        stored_code = 24'h0; calc_code = 24'h0;  // start held with other codes
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R10", "busy latency", lat, 3);
        chk("R10", "busy status", status, 1);
        chk("R10", "busy offset", byte_off, 300);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10", "no second done", done, 0);
        end
    endtask

    initial begin
        t_reset();
        t_equal(24'h000000);
        t_equal(24'hC3A517);
        t_single(24'hABCDEF, 9'd0, 3'd0);
        t_single(24'h000000, 9'd511, 3'd7);
        t_single(24'hFFFFFF, 9'd137, 3'd5);
        t_weight12();
        t_fatal("weight1", 24'h445566 ^ mk_diff(24'h000001), 24'h445566);
        t_fatal("weight11", 24'h445566 ^ mk_diff(24'h0007FF), 24'h445566);
        t_fatal("reverse erased", 24'h000000, 24'hFFFFFF);
        t_erased();
        t_busy();
        report();
    end
endmodule